// File: doc/BRIEF.md
# Memory and I/O Address Decoder

This block turns a 16-bit processor address into one-hot chip selects for the memory map of a small 8-bit system. The lower half of the map is dynamic RAM, the next quarter is a 16 KB window into one of four paged ROM sockets, and the top quarter is the operating-system ROM. Three 256-byte pages near the top of the map are taken away from the operating-system ROM and given to memory-mapped I/O. Two of these pages reach external expansion hardware and can be switched off. The third holds the internal device registers, which are split into parameterized sub-ranges.

The block also raises a slow-cycle request whenever the access targets a device that needs the reduced processor clock. It holds a write-only bank register that chooses which ROM socket answers in the paged window. A configuration input selects the small-memory variant. In that variant, RAM covers only the lowest 16 KB, and the paged window is filled by four 4 KB devices that address bits 13:12 select, in place of the bank register.

Address decoding is purely combinational. The bank register is the only state. Because it changes on a clock edge, a write to it takes effect on the access after the write.

Top module: `addr_decode_top`

## Requirements
- R1: When `small_mem`=0, addresses 0x0000–0x7FFF assert `dram_sel`. When `small_mem`=1, only 0x0000–0x3FFF assert it, and 0x4000–0x7FFF assert no select at all.
- R2: Addresses 0x8000–0xBFFF assert `pgrom_sel`.
- R3: Addresses 0xC000–0xFBFF and 0xFF00–0xFFFF assert `osrom_sel`. It is never asserted for pages 0xFC, 0xFD or 0xFE.
- R4: With `ext_en`=1, page 0xFC asserts `ext_sel[0]` and page 0xFD asserts `ext_sel[1]`. With `ext_en`=0, these pages assert no select and no `slow_req`.
- R5: Inside page 0xFE, the following offsets assert the device selects (default parameters): 0x00–0x1F gives `dev_sel[0]`, 0x40–0x5F gives `dev_sel[1]`, 0x60–0x7F gives `dev_sel[2]`, and 0xC0–0xDF gives `dev_sel[3]`. Every other offset in the page asserts no select.
- R6: `slow_req` is 1 exactly when an external page is selected, or when `dev_sel[1]`, `dev_sel[2]` or `dev_sel[3]` is asserted. It is 0 for `dev_sel[0]` and for every other address.
- R7: At most one of `dram_sel`, `pgrom_sel`, `osrom_sel`, `ext_sel`, `dev_sel` is 1 at any time.
- R8: The bank register resets to 0. It loads `wr_data[1:0]` on a rising clock edge where `wr_stb`=1, `rnw`=0 and the address is 0xFE30. It keeps its value otherwise, including on reads of 0xFE30 and on writes to other addresses.
- R9: During a paged-window access, `rom_socket` equals the bank register when `small_mem`=0, and equals address bits 13:12 when `small_mem`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Processor address |
| rnw | input | 1 | 1 = read, 0 = write |
| wr_stb | input | 1 | Write strobe for the bank register |
| wr_data | input | 2 | Data loaded into the bank register |
| small_mem | input | 1 | Small-memory variant |
| ext_en | input | 1 | Enables the two external pages |
| dram_sel | output | 1 | RAM select |
| pgrom_sel | output | 1 | Paged ROM window select |
| osrom_sel | output | 1 | Operating-system ROM select |
| ext_sel | output | 2 | External page selects (0xFC, 0xFD) |
| dev_sel | output | 4 | Internal device selects in page 0xFE |
| rom_socket | output | 2 | Paged ROM socket index |
| slow_req | output | 1 | Slow-cycle request |

## Verification
The bench sweeps every page boundary in both memory variants, with the external pages both on and off.

- **I/O hole in the OS ROM.** Page 0xFF must still select the operating-system ROM while 0xFC–0xFE do not. A decoder that masked the whole top 1 KB, or no page at all, would fail on either side of that boundary.
- **Small-memory hole.** 0x4000–0x7FFF must select nothing in the small-memory variant. A decoder that kept RAM there would drive two memories at once.
- **Internal page offsets and slow flag.** All 256 offsets of page 0xFE are walked, so a misplaced device boundary or a wrong slow flag on the fast device shows up at its exact offset.
- **Bank register.** The register is written, read back through window accesses, and then hit with reads and strobe-less writes to 0xFE30. A register that loaded on reads, or that ignored the strobe, would change the socket index seen on the next window access.

// File: rtl/addr_decode_pkg.sv
package addr_decode_pkg;
    typedef enum logic [2:0] {
        RG_NONE,
        RG_DRAM,
        RG_PGROM,
        RG_OSROM,
        RG_EXT0,
        RG_EXT1,
        RG_IOPG
    } region_e;

    localparam int ADDR_W = 16;
    localparam logic [7:0] EXT0_PAGE = 8'hFC;
    localparam logic [7:0] EXT1_PAGE = 8'hFD;
    localparam logic [7:0] IO_PAGE   = 8'hFE;
endpackage

// File: rtl/region_classifier.sv
module region_classifier
    import addr_decode_pkg::*;
(
    input  logic [7:0] page,
    input  logic       small_mem,
    input  logic       ext_en,
    output region_e    region
);
    always_comb begin
        region = RG_NONE;
        unique case (page[7:6])
            2'b00: region = RG_DRAM;
            2'b01: region = small_mem ? RG_NONE : RG_DRAM;
            2'b10: region = RG_PGROM;
            2'b11: begin
                if (page == EXT0_PAGE)      region = ext_en ? RG_EXT0 : RG_NONE;
                else if (page == EXT1_PAGE) region = ext_en ? RG_EXT1 : RG_NONE;
                else if (page == IO_PAGE)   region = RG_IOPG;
                else                        region = RG_OSROM;
            end
            default: region = RG_NONE;
        endcase
    end
endmodule

// File: rtl/io_page_decoder.sv
module io_page_decoder #(
    parameter int                  NUM_DEV   = 4,
    parameter logic [NUM_DEV*8-1:0] DEV_LO   = {8'hC0, 8'h60, 8'h40, 8'h00},
    parameter logic [NUM_DEV*8-1:0] DEV_HI   = {8'hDF, 8'h7F, 8'h5F, 8'h1F},
    parameter logic [NUM_DEV-1:0]  SLOW_MASK = 4'b1110
) (
    input  logic               en,
    input  logic [7:0]         offset,
    output logic [NUM_DEV-1:0] dev_sel,
    output logic               dev_slow
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
        assign dev_sel[i] = en && (offset >= DEV_LO[i*8 +: 8]) && (offset <= DEV_HI[i*8 +: 8]);
    end

    assign dev_slow = |(dev_sel & SLOW_MASK);
endmodule

// File: rtl/rom_bank_latch.sv
module rom_bank_latch #(
    parameter int SOCK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SOCK_W-1:0] d,
    output logic [SOCK_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R8: no write strobe means the bank does not move
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
    // R8: a write lands the data
    a_r8_load_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(d));
endmodule

// File: rtl/addr_decode_top.sv
module addr_decode_top
    import addr_decode_pkg::*;
#(
    parameter int                   NUM_DEV    = 4,
    parameter logic [NUM_DEV*8-1:0] DEV_LO     = {8'hC0, 8'h60, 8'h40, 8'h00},
    parameter logic [NUM_DEV*8-1:0] DEV_HI     = {8'hDF, 8'h7F, 8'h5F, 8'h1F},
    parameter logic [NUM_DEV-1:0]   SLOW_MASK  = 4'b1110,
    parameter logic [7:0]           BANK_OFFS  = 8'h30,
    parameter int                   NUM_SOCK   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [15:0]                 addr,
    input  logic                        rnw,
    input  logic                        wr_stb,
    input  logic [$clog2(NUM_SOCK)-1:0] wr_data,
    input  logic                        small_mem,
    input  logic                        ext_en,
    output logic                        dram_sel,
    output logic                        pgrom_sel,
    output logic                        osrom_sel,
    output logic [1:0]                  ext_sel,
    output logic [NUM_DEV-1:0]          dev_sel,
    output logic [$clog2(NUM_SOCK)-1:0] rom_socket,
    output logic                        slow_req
);
    localparam int SOCK_W = $clog2(NUM_SOCK);

    region_e            region;
    logic               dev_slow;
    logic               bank_we;
    logic [SOCK_W-1:0]  bank_q;

    region_classifier u_region (
        .page      (addr[15:8]),
        .small_mem (small_mem),
        .ext_en    (ext_en),
        .region    (region)
    );

    io_page_decoder #(
        .NUM_DEV   (NUM_DEV),
        .DEV_LO    (DEV_LO),
        .DEV_HI    (DEV_HI),
        .SLOW_MASK (SLOW_MASK)
    ) u_io (
        .en       (region == RG_IOPG),
        .offset   (addr[7:0]),
        .dev_sel  (dev_sel),
        .dev_slow (dev_slow)
    );

    assign bank_we = wr_stb && !rnw && (addr == {IO_PAGE, BANK_OFFS});

    rom_bank_latch #(.SOCK_W(SOCK_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .d     (wr_data),
        .q     (bank_q)
    );

    always_comb begin
        dram_sel  = 1'b0;
        pgrom_sel = 1'b0;
        osrom_sel = 1'b0;
        ext_sel   = 2'b00;
        unique case (region)
            RG_DRAM:  dram_sel   = 1'b1;
            RG_PGROM: pgrom_sel  = 1'b1;
            RG_OSROM: osrom_sel  = 1'b1;
            RG_EXT0:  ext_sel[0] = 1'b1;
            RG_EXT1:  ext_sel[1] = 1'b1;
            RG_IOPG, RG_NONE: ;
            default: ;
        endcase
    end

    assign rom_socket = small_mem ? addr[12 +: SOCK_W] : bank_q;
    assign slow_req   = (|ext_sel) || dev_slow;

    // R7: selects are mutually exclusive
    a_r7_onehot_selects: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_sel, pgrom_sel, osrom_sel, ext_sel, dev_sel}));
    // R3: OS ROM is masked over the three I/O pages
    a_r3_rom_masked_io: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:8] >= EXT0_PAGE && addr[15:8] <= IO_PAGE) |-> !osrom_sel);
    // R4: disabled external pages stay silent
    a_r4_ext_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_en |-> (ext_sel == 2'b00));
    // R6: external page accesses are always slow
    a_r6_ext_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_sel != 2'b00) |-> slow_req);
    // R1: small-memory hole selects no RAM
    a_r1_small_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (small_mem && addr[15:14] == 2'b01) |-> !dram_sel);
endmodule

// File: tb/addr_decode_top_tb.sv
`timescale 1ns/1ps
module addr_decode_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        rnw = 1'b1;
    logic        wr_stb = 1'b0;
    logic [1:0]  wr_data = 2'b00;
    logic        small_mem = 1'b0;
    logic        ext_en = 1'b1;
    logic        dram_sel, pgrom_sel, osrom_sel, slow_req;
    logic [1:0]  ext_sel, rom_socket;
    logic [3:0]  dev_sel;

    int checks = 0;
    int fails = 0;
    int exp_bank = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addr_decode_top u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rnw(rnw), .wr_stb(wr_stb),
        .wr_data(wr_data), .small_mem(small_mem), .ext_en(ext_en),
        .dram_sel(dram_sel), .pgrom_sel(pgrom_sel), .osrom_sel(osrom_sel),
        .ext_sel(ext_sel), .dev_sel(dev_sel), .rom_socket(rom_socket),
        .slow_req(slow_req)
    );

    task automatic chk(input string tag, input int got, input int exp, input int a);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, a, got, exp);
        end
    endtask

    task automatic compare_all(input int a);
        int pg, off, e_dev, e_ext, e_sock, nsel;
        bit e_dr, e_pr, e_os, e_sl;
        pg  = a / 256;
        off = a % 256;
        e_dr = small_mem ? (a < 'h4000) : (a < 'h8000);
        e_pr = (a >= 'h8000) && (a < 'hC000);
        e_os = (a >= 'hC000) && !(pg >= 'hFC && pg <= 'hFE);
        e_ext = 0;
        if (ext_en && pg == 'hFC) e_ext = 1;
        if (ext_en && pg == 'hFD) e_ext = 2;
        e_dev = 0;
        if (pg == 'hFE) begin
            if (off <= 'h1F)                e_dev = 1;
            if (off >= 'h40 && off <= 'h5F) e_dev = 2;
            if (off >= 'h60 && off <= 'h7F) e_dev = 4;
            if (off >= 'hC0 && off <= 'hDF) e_dev = 8;
        end
        e_sl = (e_ext != 0) || (e_dev > 1);
        e_sock = small_mem ? (a / 4096) % 4 : exp_bank;
        chk("R1 dram_sel", dram_sel, e_dr, a);
        chk("R2 pgrom_sel", pgrom_sel, e_pr, a);
        chk("R3 osrom_sel", osrom_sel, e_os, a);
        chk("R4 ext_sel", ext_sel, e_ext, a);
        chk("R5 dev_sel", dev_sel, e_dev, a);
        chk("R6 slow_req", slow_req, e_sl, a);
        nsel = dram_sel + pgrom_sel + osrom_sel + $countones(ext_sel) + $countones(dev_sel);
        chk("R7 select count", nsel <= 1, 1, a);
        if (e_pr) chk("R9 rom_socket", rom_socket, e_sock, a);
    endtask

    // one access: drive after the edge, compare mid-cycle, then model the write
    task automatic access(input int a, input bit r, input bit w, input int d);
        @(posedge clk);
        #1;
        addr = a[15:0]; rnw = r; wr_stb = w; wr_data = d[1:0];
        @(negedge clk);
        compare_all(a);
        if (w && !r && a == 'hFE30) exp_bank = d % 4; // R8 model
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        addr = 16'h9000;
        #15;
        chk("R8 reset bank", rom_socket, 0, 'h9000);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        access('h9000, 1, 0, 0);
        chk("R8 bank after reset", rom_socket, 0, 'h9000);

        // page sweep, all four configurations (R1..R7)
        for (int cfg = 0; cfg < 4; cfg++) begin
            small_mem = cfg[0];
            ext_en    = cfg[1];
            for (int p = 0; p < 256; p++) begin
                access(p * 256, 1, 0, 0);
                access(p * 256 + 255, 1, 0, 0);
            end
        end

        // page 0xFE walk (R5, R6)
        small_mem = 1'b0; ext_en = 1'b1;
        for (int o = 0; o < 256; o++) access('hFE00 + o, 1, 0, 0);

        // bank register (R8, R9)
        for (int b = 3; b >= 0; b--) begin
            access('hFE30, 0, 1, b);
            access('hA123, 1, 0, 0);
            chk("R8 bank load", rom_socket, b, 'hA123);
        end
        access('hFE30, 0, 1, 2);
        access('hFE30, 1, 1, 1);      // read: ignored
        access('hFE30, 0, 0, 3);      // no strobe: ignored
        access('hFE31, 0, 1, 0);      // other address: ignored
        access('hBFFF, 1, 0, 0);
        chk("R8 bank unchanged", rom_socket, 2, 'hBFFF);

        // small-memory window uses A13:A12 (R9)
        small_mem = 1'b1;
        for (int s = 0; s < 4; s++) access('h8000 + s * 'h1000 + 'h55, 1, 0, 0);
        small_mem = 1'b0;
        access('h8000, 1, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule